// File: doc/BRIEF.md
# Streaming Hamming Parity Accumulator for Flash Chunks

This block builds a 24-bit single-error-correcting Hamming code over one chunk of flash data while that data moves across an 8-bit or 16-bit bus. A controller pulses `start` before a chunk, together with the bus width and the chunk length. From then on, every valid beat on the data input folds one byte (8-bit mode) or two bytes (16-bit mode) into twelve pairs of even/odd parities. The accumulator stops after the programmed number of bytes and holds `done` high until the next `start`.

The parities are published in two forms. The first is a 32-bit result word, with the even half of each pair in the low field and the odd half in the upper field. The second is a 3-byte packed code, ready to be stored in the spare area. The same accumulation serves both directions. On a program, the code is written out. On a read-back, the controller compares the recomputed code with the stored one.

Top module: `hecc_acc`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0, and valid beats are ignored until the first `start`.
- R2: Pair i (i = 0..11, covering parity distance 2^i) has its even member at `result[i]` and its odd member at `result[16+i]`. Bits 15:12 and 31:28 are zero.
- R3: The column pairs cover bit positions within each byte. Pair 0 odd covers bits {1,3,5,7}, pair 1 odd covers bits {2,3,6,7}, and pair 2 odd covers bits {4,5,6,7}. The even member of each pair covers the remaining four bits.
- R4: Line pair 3+j (j = 0..8) is the XOR of all bits of the bytes whose chunk byte index has bit j set (odd member) or clear (even member). The first byte of a chunk has index 0.
- R5: When `wide16` is 1 at `start`, each beat carries two bytes: `beat_data[7:0]` is the byte at the even index and `beat_data[15:8]` is the byte at the next index. When `wide16` is 0, only `beat_data[7:0]` counts, one byte per beat.
- R6: A chunk holds 2*(`half_m1`+1) bytes. `done` rises in the cycle after the beat that completes the chunk. It then stays high, and `result` stays unchanged under further beats until the next `start`.
- R7: `start` clears all parities and `done`, and latches `wide16` and `half_m1`. A valid beat in the same cycle as `start` is discarded.
- R8: `code[7:0]` = `result[7:0]` and `code[15:8]` = `result[23:16]`. `code[19:16]` = `result[11:8]` and `code[23:20]` = `result[27:24]`.
- R9: The parities are not inverted: a chunk whose bytes are all 0xFF yields `result` = 0 and `code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear and arm for a new chunk |
| wide16 | input | 1 | Bus width at start: 1 = 16-bit, 0 = 8-bit |
| half_m1 | input | SZ_W | Chunk length in bytes, halved, minus one |
| beat_valid | input | 1 | Data beat present |
| beat_data | input | 16 | Beat payload |
| result | output | 32 | Even parities 11:0, odd parities 27:16 |
| code | output | 24 | Packed 3-byte spare-area code |
| done | output | 1 | Chunk complete, parities frozen |

## Verification
Two functions can collide in one cycle: a clear caused by `start`, and a data beat being folded in. The bench raises `start` while `beat_valid` carries a nonzero byte. It then streams a chunk whose expected code excludes that byte, so any absorbed beat shows up as a code mismatch. The bench also restarts in the middle of a chunk with a different width and length, and it keeps sending beats after `done` to confirm that the frozen result is held.

// File: rtl/hecc_acc.sv
module hecc_acc #(
  parameter int SZ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wide16,
  input  logic [SZ_W-1:0] half_m1,
  input  logic            beat_valid,
  input  logic [15:0]     beat_data,
  output logic [31:0]     result,
  output logic [23:0]     code,
  output logic            done
);
  localparam int IDX_W = SZ_W + 1;
  localparam int NP    = 3 + IDX_W;
  localparam int CNT_W = IDX_W + 1;
  localparam int PAD   = 16 - NP;

  logic             en, wide_q, done_q;
  logic [SZ_W-1:0]  size_q;
  logic [CNT_W-1:0] cnt, cnt_nxt, limit;
  logic [NP-1:0]    acc_e, acc_o;
  logic [2*NP-1:0]  lo_c, hi_c;
  logic             take;

  function automatic logic [2*NP-1:0] fold(input logic [7:0] b, input logic [IDX_W-1:0] k);
    logic [NP-1:0] e, o;
    logic p;
    p    = ^b;
    e[0] = ^(b & 8'h55);  o[0] = ^(b & 8'hAA);
    e[1] = ^(b & 8'h33);  o[1] = ^(b & 8'hCC);
    e[2] = ^(b & 8'h0F);  o[2] = ^(b & 8'hF0);
    for (int j = 0; j < IDX_W; j++) begin
      o[3+j] = p & k[j];
      e[3+j] = p & ~k[j];
    end
    return {o, e};
  endfunction

  assign take    = en & beat_valid & ~done_q & ~start;
  assign limit   = CNT_W'({1'b0, size_q} + 1'b1) << 1;
  assign cnt_nxt = cnt + (wide_q ? CNT_W'(2) : CNT_W'(1));
  assign lo_c    = fold(beat_data[7:0], cnt[IDX_W-1:0]);
  assign hi_c    = wide_q ? fold(beat_data[15:8], cnt[IDX_W-1:0] | IDX_W'(1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      wide_q <= 1'b0;
      size_q <= '0;
      cnt    <= '0;
      acc_e  <= '0;
      acc_o  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      en     <= 1'b1;
      wide_q <= wide16;
      size_q <= half_m1;
      cnt    <= '0;
      acc_e  <= '0;
      acc_o  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      cnt    <= cnt_nxt;
      acc_e  <= acc_e ^ lo_c[NP-1:0] ^ hi_c[NP-1:0];
      acc_o  <= acc_o ^ lo_c[2*NP-1:NP] ^ hi_c[2*NP-1:NP];
      done_q <= (cnt_nxt == limit);
    end
  end

  assign result = {{PAD{1'b0}}, acc_o, {PAD{1'b0}}, acc_e};
  assign code   = {result[27:24], result[11:8], result[23:16], result[7:0]};
  assign done   = done_q;
endmodule

// File: rtl/hecc_acc_chk.sv
module hecc_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        beat_valid,
  input logic [31:0] result,
  input logic        done
);
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (result == 32'd0 && !done));

  assert_frozen_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(result));

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_change_needs_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(result) && !$past(start)) |-> $past(beat_valid));

  assert_done_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(beat_valid));
endmodule

bind hecc_acc hecc_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .beat_valid(beat_valid),
  .result(result), .done(done)
);

// File: tb/hecc_acc_tb.sv
module hecc_acc_tb;
  logic        clk = 0, rst_n = 0, start = 0, wide16 = 0, beat_valid = 0;
  logic [7:0]  half_m1 = 0;
  logic [15:0] beat_data = 0;
  logic [31:0] result;
  logic [23:0] code;
  logic        done;

  int n_tests = 0, n_fail = 0;
  logic [7:0]  mem [512];
  logic [31:0] q_res [$];
  logic [23:0] q_code [$];
  logic        done_seen = 0;

  always #10 clk = ~clk;

  hecc_acc u_dut (.clk(clk), .rst_n(rst_n), .start(start), .wide16(wide16),
    .half_m1(half_m1), .beat_valid(beat_valid), .beat_data(beat_data),
    .result(result), .code(code), .done(done));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_expected(input int nbytes);
    logic [11:0] e = 0, o = 0;
    for (int k = 0; k < nbytes; k++)
      for (int b = 0; b < 8; b++)
        if (mem[k][b]) begin
          for (int i = 0; i < 3; i++)
            if ((b >> i) & 1) o[i] ^= 1'b1; else e[i] ^= 1'b1;
          for (int j = 0; j < 9; j++)
            if ((k >> j) & 1) o[3+j] ^= 1'b1; else e[3+j] ^= 1'b1;
        end
    q_res.push_back({4'h0, o, 4'h0, e});
    q_code.push_back({o[11:8], e[11:8], o[7:0], e[7:0]});
  endtask

  task automatic fill(input int nbytes, input int kind, input int seed, input int fb, input int fbit);
    for (int k = 0; k < nbytes; k++) begin
      if (kind == 1) mem[k] = 8'((k * 37 + seed) ^ (k >> 3));
      else mem[k] = 8'hFF;
      if (kind == 2 && k == fb) mem[k][fbit] = 1'b0;
    end
  endtask

  task automatic do_start(input bit w, input int h, input bit with_beat);
    @(posedge clk); #2;
    start = 1; wide16 = w; half_m1 = 8'(h);
    beat_valid = with_beat; beat_data = 16'h0101;
    @(posedge clk); #2;
    start = 0; beat_valid = 0;
  endtask

  task automatic stream(input bit w, input int nbytes, input int upto);
    int nbeats = w ? nbytes / 2 : nbytes;
    for (int i = 0; i < nbeats && i < upto; i++) begin
      if (i % 5 == 4) begin @(posedge clk); #2; beat_valid = 0; end
      @(posedge clk); #2;
      beat_valid = 1;
      beat_data  = w ? {mem[2*i+1], mem[2*i]} : {8'hA5, mem[i]};
      if (i == nbeats - 1) begin
        @(negedge clk);
        check(done == 1'b0, "R6 done early", {31'd0, done}, 0);
      end
    end
    @(posedge clk); #2; beat_valid = 0;
    if (upto >= nbeats) begin
      @(negedge clk);
      check(done == 1'b1, "R6 done after last beat", {31'd0, done}, 1);
    end
  endtask

  task automatic chunk(input bit w, input int h, input int kind, input int seed, input int fb, input int fbit);
    int nb = 2 * (h + 1);
    fill(nb, kind, seed, fb, fbit);
    push_expected(nb);
    do_start(w, h, 0);
    stream(w, nb, 1 << 20);
    repeat (2) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !done_seen) begin
      if (q_res.size() == 0) check(0, "R6 unexpected done", result, 0);
      else begin
        logic [31:0] er;
        logic [23:0] ec;
        er = q_res.pop_front();
        ec = q_code.pop_front();
        check(result == er, "R2 R3 R4 R5 result", result, er);
        check(code == ec, "R8 packed code", {8'h0, code}, {8'h0, ec});
      end
    end
    done_seen = done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(result == 0 && done == 0, "R1 reset state", result, 0);

    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2; beat_valid = 1; beat_data = 16'h1234 + 16'(i);
    end
    @(posedge clk); #2; beat_valid = 0;
    @(negedge clk);
    check(result == 0 && done == 0, "R1 beats before start ignored", result, 0);

    chunk(0, 3, 1, 11, 0, 0);
    chunk(1, 3, 1, 29, 0, 0);
    chunk(0, 7, 1, 5, 0, 0);

    chunk(0, 255, 0, 0, 0, 0);
    check(result == 0 && code == 0, "R9 all-FF gives zero", result, 0);

    chunk(1, 255, 2, 0, 301, 5);
    chunk(0, 255, 2, 0, 511, 7);

    held = result;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2; beat_valid = 1; beat_data = 16'hBEEF;
    end
    @(posedge clk); #2; beat_valid = 0;
    @(negedge clk);
    check(result == held, "R6 frozen after done", result, held);
    check(done == 1'b1, "R6 done held", {31'd0, done}, 1);

    fill(8, 1, 77, 0, 0);
    push_expected(8);
    do_start(0, 3, 1);
    @(negedge clk);
    check(result == 0 && done == 0, "R7 start with beat clears", result, 0);
    stream(0, 8, 1 << 20);
    repeat (2) @(posedge clk);

    fill(16, 1, 3, 0, 0);
    do_start(1, 7, 0);
    stream(1, 16, 3);
    fill(6, 1, 91, 0, 0);
    push_expected(6);
    do_start(0, 2, 0);
    @(negedge clk);
    check(result == 0 && done == 0, "R7 restart mid-chunk clears", result, 0);
    stream(0, 6, 1 << 20);
    repeat (3) @(posedge clk);

    check(q_res.size() == 0, "R6 all chunks completed", q_res.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule